// File: doc/BRIEF.md
# Effective Address Calculator

This block turns the addressing fields of a decoded instruction into the address of its operand. It takes a mode code, a base register value, an index register value, the program counter, a 16-bit displacement and a full-width address field. From these it forms one of eight address expressions: register plus displacement, two-register sums with or without a displacement, index scaled by 1, 2, 4 or 8, program-counter relative, and two forms that go through memory.

Direct forms return their result one cycle after `start`. The two memory forms run a single read on a simple request/acknowledge port and then return a result built from the word read. In pre-indexed form the index is added before the read, and the word read is the address. In post-indexed form the address field is read first, and the index is added to the word read. A pipeline front end pulses `start` and waits for `done`. A mode code it does not recognise ends the request with an error flag.

Top module: `eff_addr_calc`

## Requirements
- R1: Mode 0 returns base + displacement. The 16-bit displacement is sign-extended to 32 bits (bit 15 is the sign). Every sum in every mode wraps modulo 2^32.
- R2: Mode 1 returns base + index and ignores the displacement. Mode 2 returns base + index + displacement. The scale code has no effect in modes 0, 1, 2 and 5.
- R3: Mode 3 returns (index << s) + displacement and ignores base. Mode 4 returns base + (index << s) + displacement. Here s is the 2-bit scale code, giving factors 1, 2, 4 and 8, and bits shifted above bit 31 are lost.
- R4: Mode 5 returns program counter + displacement and ignores base and index.
- R5: Mode 6 (pre-indexed) reads memory at address field + index. The word read is the result.
- R6: Mode 7 (post-indexed) reads memory at the address field. The result is the word read plus the index value captured when `start` was accepted. Later changes on the index input have no effect.
- R7: When idle, a `start` with mode 0 to 5 gives a one-cycle `done` pulse with `err` low in the next cycle, and `ea_out` holds the result from then on.
- R8: In modes 6 and 7, `mem_req` rises in the cycle after `start` and stays high with a stable `mem_addr` until `mem_ack` is sampled high. In the next cycle `done` pulses with the result and `mem_req` is low. `mem_ack` has no effect while no read is pending.
- R9: Mode codes 8 to 15 give `done` and `err` together in the cycle after `start`, with `ea_out` zero. No memory read is issued.
- R10: A `start` that arrives while a read is pending is ignored. It gives no `done`, and the pending read keeps its address.
- R11: After reset, `done`, `err` and `mem_req` are low and `ea_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a calculation (accepted when idle) |
| mode | input | 4 | Address form select, codes 0 to 7 defined |
| scale | input | 2 | Index scale code: shift left by 0 to 3 |
| base_val | input | 32 | Base register contents |
| index_val | input | 32 | Index register contents |
| pc_val | input | 32 | Program counter |
| disp | input | 16 | Signed displacement field |
| addr_field | input | 32 | Address field used by the memory forms |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | 32 | Read address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Undefined mode, valid with done |
| ea_out | output | 32 | Effective address |

## Verification
A vector table runs each direct form with non-zero values on every input, so a mode that picks the wrong operand, ignores the scale code or applies it where it does not belong gives a wrong sum. Negative displacements, a base near the top of the address space, and an index whose scaled value overflows 32 bits separate correct sign extension and modulo wrap from zero extension or saturation. The memory forms run with differing wait lengths and with the index changed after acceptance. These runs tell pre-indexed from post-indexed order, and a captured index from a live one. Directed cases cover a stray start or acknowledge while the block is busy or idle, and codes 8 and 15.

// File: rtl/eac_pkg.sv
package eac_pkg;

    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] MODE_BASE_DISP     = 4'd0;
    localparam logic [MODE_W-1:0] MODE_BASE_IDX      = 4'd1;
    localparam logic [MODE_W-1:0] MODE_BASE_IDX_DISP = 4'd2;
    localparam logic [MODE_W-1:0] MODE_SIDX_DISP     = 4'd3;
    localparam logic [MODE_W-1:0] MODE_BASE_SIDX_DSP = 4'd4;
    localparam logic [MODE_W-1:0] MODE_PC_REL        = 4'd5;
    localparam logic [MODE_W-1:0] MODE_PRE_INDIRECT  = 4'd6;
    localparam logic [MODE_W-1:0] MODE_POST_INDIRECT = 4'd7;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } eac_state_e;

endpackage

// File: rtl/eac_scaler.sv
module eac_scaler #(
    parameter int AW = 32,
    parameter int SW = 2
) (
    input  logic [AW-1:0] idx_in,
    input  logic [SW-1:0] scale_code,
    output logic [AW-1:0] idx_scaled
);
    localparam int NSHIFT = 1 << SW;

    logic [AW-1:0] shifted [NSHIFT];

    generate
        for (genvar k = 0; k < NSHIFT; k++) begin : g_shift
            assign shifted[k] = idx_in << k;
        end
    endgenerate

    assign idx_scaled = shifted[scale_code];
endmodule

// File: rtl/eac_adder3.sv
module eac_adder3 #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] op_a,
    input  logic [AW-1:0] op_b,
    input  logic [AW-1:0] op_c,
    output logic [AW-1:0] sum
);
    assign sum = op_a + op_b + op_c;
endmodule

// File: rtl/eac_operand_sel.sv
module eac_operand_sel
    import eac_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 16,
    parameter int SW = 2
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [SW-1:0]     scale,
    input  logic [AW-1:0]     base_val,
    input  logic [AW-1:0]     index_val,
    input  logic [AW-1:0]     pc_val,
    input  logic [DW-1:0]     disp,
    input  logic [AW-1:0]     addr_field,
    output logic [AW-1:0]     op_a,
    output logic [AW-1:0]     op_b,
    output logic [AW-1:0]     op_c,
    output logic              needs_read,
    output logic              post_index,
    output logic              illegal
);
    localparam int EXT_W = AW - DW;

    logic [AW-1:0] disp_ext;
    logic [AW-1:0] idx_scaled;

    assign disp_ext = {{EXT_W{disp[DW-1]}}, disp};

    eac_scaler #(.AW(AW), .SW(SW)) u_scaler (
        .idx_in     (index_val),
        .scale_code (scale),
        .idx_scaled (idx_scaled)
    );

    always_comb begin
        op_a       = '0;
        op_b       = '0;
        op_c       = '0;
        needs_read = 1'b0;
        post_index = 1'b0;
        illegal    = 1'b0;
        case (mode)
            MODE_BASE_DISP: begin
                op_a = base_val;
                op_c = disp_ext;
            end
            MODE_BASE_IDX: begin
                op_a = base_val;
                op_b = index_val;
            end
            MODE_BASE_IDX_DISP: begin
                op_a = base_val;
                op_b = index_val;
                op_c = disp_ext;
            end
            MODE_SIDX_DISP: begin
                op_b = idx_scaled;
                op_c = disp_ext;
            end
            MODE_BASE_SIDX_DSP: begin
                op_a = base_val;
                op_b = idx_scaled;
                op_c = disp_ext;
            end
            MODE_PC_REL: begin
                op_a = pc_val;
                op_c = disp_ext;
            end
            MODE_PRE_INDIRECT: begin
                op_a       = addr_field;
                op_b       = index_val;
                needs_read = 1'b1;
            end
            MODE_POST_INDIRECT: begin
                op_a       = addr_field;
                needs_read = 1'b1;
                post_index = 1'b1;
            end
            default: begin
                illegal = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/eff_addr_calc.sv
module eff_addr_calc
    import eac_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 16,
    parameter int SW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic [SW-1:0]     scale,
    input  logic [AW-1:0]     base_val,
    input  logic [AW-1:0]     index_val,
    input  logic [AW-1:0]     pc_val,
    input  logic [DW-1:0]     disp,
    input  logic [AW-1:0]     addr_field,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_ack,
    input  logic [AW-1:0]     mem_rdata,
    output logic              done,
    output logic              err,
    output logic [AW-1:0]     ea_out
);
    typedef struct packed {
        eac_state_e    state;
        logic          mem_req;
        logic [AW-1:0] mem_addr;
        logic          done;
        logic          err;
        logic [AW-1:0] ea;
        logic [AW-1:0] idx_hold;
        logic          post;
    } eac_regs_t;

    eac_regs_t regs_d, regs_q;

    logic [AW-1:0] sel_a, sel_b, sel_c;
    logic          sel_read, sel_post, sel_illegal;
    logic [AW-1:0] front_sum;
    logic [AW-1:0] back_sum;
    logic [AW-1:0] back_idx;

    eac_operand_sel #(.AW(AW), .DW(DW), .SW(SW)) u_sel (
        .mode       (mode),
        .scale      (scale),
        .base_val   (base_val),
        .index_val  (index_val),
        .pc_val     (pc_val),
        .disp       (disp),
        .addr_field (addr_field),
        .op_a       (sel_a),
        .op_b       (sel_b),
        .op_c       (sel_c),
        .needs_read (sel_read),
        .post_index (sel_post),
        .illegal    (sel_illegal)
    );

    eac_adder3 #(.AW(AW)) u_front_add (
        .op_a (sel_a),
        .op_b (sel_b),
        .op_c (sel_c),
        .sum  (front_sum)
    );

    assign back_idx = regs_q.post ? regs_q.idx_hold : '0;

    eac_adder3 #(.AW(AW)) u_back_add (
        .op_a (mem_rdata),
        .op_b (back_idx),
        .op_c ('0),
        .sum  (back_sum)
    );

    always_comb begin
        regs_d      = regs_q;
        regs_d.done = 1'b0;
        regs_d.err  = 1'b0;
        case (regs_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (sel_illegal) begin
                        regs_d.done = 1'b1;
                        regs_d.err  = 1'b1;
                        regs_d.ea   = '0;
                    end else if (sel_read) begin
                        regs_d.state    = ST_WAIT;
                        regs_d.mem_req  = 1'b1;
                        regs_d.mem_addr = front_sum;
                        regs_d.idx_hold = index_val;
                        regs_d.post     = sel_post;
                    end else begin
                        regs_d.done = 1'b1;
                        regs_d.ea   = front_sum;
                    end
                end
            end
            ST_WAIT: begin
                if (mem_ack) begin
                    regs_d.state   = ST_IDLE;
                    regs_d.mem_req = 1'b0;
                    regs_d.done    = 1'b1;
                    regs_d.ea      = back_sum;
                end
            end
            default: begin
                regs_d.state   = ST_IDLE;
                regs_d.mem_req = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{state: ST_IDLE, mem_req: 1'b0, mem_addr: '0, done: 1'b0,
                        err: 1'b0, ea: '0, idx_hold: '0, post: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mem_req  = regs_q.mem_req;
    assign mem_addr = regs_q.mem_addr;
    assign done     = regs_q.done;
    assign err      = regs_q.err;
    assign ea_out   = regs_q.ea;
endmodule

// File: rtl/eac_checker.sv
module eac_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [3:0]    mode,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ack,
    input logic          done,
    input logic          err,
    input logic [AW-1:0] ea_out
);
    // R7: a direct form finishes in the next cycle without error
    a_r7_direct_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mem_req && mode <= 4'd5) |=> (done && !err && !mem_req));

    // R8: a memory form opens a read and does not finish yet
    a_r8_read_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mem_req && (mode == 4'd6 || mode == 4'd7)) |=> (mem_req && !done));

    // R8: request and address held until acknowledged
    a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R8: acknowledge closes the read and strobes done
    a_r8_ack_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (done && !err && !mem_req));

    // R9: an undefined code reports an error with done
    a_r9_bad_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !mem_req && mode >= 4'd8) |=> (done && err && !mem_req));

    // R9: error always comes with done and a zero address
    a_r9_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && ea_out == '0));

    // R10: no completion while a read is still pending
    a_r10_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> !done);
endmodule

bind eff_addr_calc eac_checker #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mode     (mode),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .done     (done),
    .err      (err),
    .ea_out   (ea_out)
);

// File: tb/eff_addr_calc_test.sv
`timescale 1ns/1ps
module eff_addr_calc_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [1:0]  scale = '0;
    logic [31:0] base_val = '0;
    logic [31:0] index_val = '0;
    logic [31:0] pc_val = '0;
    logic [15:0] disp = '0;
    logic [31:0] addr_field = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic        err;
    logic [31:0] ea_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    eff_addr_calc uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode       (mode),
        .scale      (scale),
        .base_val   (base_val),
        .index_val  (index_val),
        .pc_val     (pc_val),
        .disp       (disp),
        .addr_field (addr_field),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .done       (done),
        .err        (err),
        .ea_out     (ea_out)
    );

    typedef struct packed {
        logic [3:0]  m;
        logic [1:0]  s;
        logic [31:0] b;
        logic [31:0] x;
        logic [31:0] p;
        logic [15:0] d;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{4'd0, 2'd0, 32'h00001000, 32'h00000000, 32'h00000000, 16'h0010, 32'h00001010},
        '{4'd0, 2'd0, 32'h00001000, 32'h00000000, 32'h00000000, 16'hFFF0, 32'h00000FF0},
        '{4'd0, 2'd2, 32'hFFFFFFF0, 32'h00000005, 32'h00000000, 16'h0020, 32'h00000010},
        '{4'd1, 2'd3, 32'h00002000, 32'h00000300, 32'h00000000, 16'h1234, 32'h00002300},
        '{4'd2, 2'd0, 32'h00002000, 32'h00000300, 32'h00000000, 16'h0004, 32'h00002304},
        '{4'd2, 2'd0, 32'h00002000, 32'h00000010, 32'h00000000, 16'h8000, 32'hFFFFA010},
        '{4'd3, 2'd0, 32'hDEAD0000, 32'h00000100, 32'h00000000, 16'h0008, 32'h00000108},
        '{4'd3, 2'd3, 32'hDEAD0000, 32'h00000100, 32'h00000000, 16'h0008, 32'h00000808},
        '{4'd4, 2'd1, 32'h00004000, 32'h00000030, 32'h00000000, 16'h0002, 32'h00004062},
        '{4'd4, 2'd2, 32'h00004000, 32'h00000030, 32'h00000000, 16'hFFFE, 32'h000040BE},
        '{4'd4, 2'd3, 32'h00000001, 32'h30000000, 32'h00000000, 16'h0000, 32'h80000001},
        '{4'd5, 2'd0, 32'h00000000, 32'h00000000, 32'h00400000, 16'hFFFC, 32'h003FFFFC},
        '{4'd5, 2'd1, 32'h00000999, 32'h00000007, 32'h00000100, 16'h0040, 32'h00000140}
    };

    function automatic string req_of(input logic [3:0] m);
        case (m)
            4'd0:         return "R1";
            4'd1, 4'd2:   return "R2";
            4'd3, 4'd4:   return "R3";
            default:      return "R4";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_indirect(input string req, input logic [3:0] m,
                                input logic [31:0] af, input logic [31:0] ix,
                                input int waits, input logic [31:0] exp_addr,
                                input logic [31:0] rdata, input logic [31:0] exp_ea);
        @(negedge clk);
        mode = m; addr_field = af; index_val = ix; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        index_val = 32'h00000999;
        check("R8", "req raised", {31'd0, mem_req}, 32'd1);
        check(req, "read address", mem_addr, exp_addr);
        check("R8", "no early done", {31'd0, done}, 32'd0);
        for (int w = 0; w < waits; w++) begin
            if (w == 0) begin
                start = 1'b1;
                mode  = 4'd0;
            end
            @(negedge clk);
            start = 1'b0;
            mode  = m;
            check("R10", "busy no done", {31'd0, done}, 32'd0);
            check("R8", "req held", {31'd0, mem_req}, 32'd1);
            check("R10", "address kept", mem_addr, exp_addr);
        end
        mem_ack = 1'b1; mem_rdata = rdata;
        @(negedge clk);
        mem_ack = 1'b0; mem_rdata = 32'hBADBAD00;
        check("R8", "done after ack", {31'd0, done}, 32'd1);
        check("R8", "req dropped", {31'd0, mem_req}, 32'd0);
        check(req, "result", ea_out, exp_ea);
        check(req, "no error", {31'd0, err}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "done", {31'd0, done}, 32'd0);
        check("R11", "err", {31'd0, err}, 32'd0);
        check("R11", "mem_req", {31'd0, mem_req}, 32'd0);
        check("R11", "ea_out", ea_out, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // direct-form vector table
        for (int i = 0; i < NVEC; i++) begin
            mode = VECS[i].m; scale = VECS[i].s; base_val = VECS[i].b;
            index_val = VECS[i].x; pc_val = VECS[i].p; disp = VECS[i].d;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check("R7", "done strobe", {31'd0, done}, 32'd1);
            check("R7", "err low", {31'd0, err}, 32'd0);
            check(req_of(VECS[i].m), "address", ea_out, VECS[i].exp);
            @(negedge clk);
            check("R7", "done one cycle", {31'd0, done}, 32'd0);
            check("R7", "result held", ea_out, VECS[i].exp);
        end

        // R8: acknowledge while idle has no effect
        mem_ack = 1'b1; mem_rdata = 32'h12345678;
        @(negedge clk);
        mem_ack = 1'b0;
        check("R8", "idle ack done", {31'd0, done}, 32'd0);
        check("R8", "idle ack ea", ea_out, 32'h00000140);

        // R5: pre-indexed, index added before the read
        run_indirect("R5", 4'd6, 32'h00010000, 32'h00000024, 3, 32'h00010024,
                     32'hCAFE0000, 32'hCAFE0000);
        // R6: post-indexed, captured index added to the word read
        run_indirect("R6", 4'd7, 32'h00020000, 32'h00000010, 2, 32'h00020000,
                     32'h00300000, 32'h00300010);
        // R5: wrapping read address, immediate acknowledge
        run_indirect("R5", 4'd6, 32'hFFFFFFF0, 32'h00000020, 0, 32'h00000010,
                     32'h00000055, 32'h00000055);
        // R6: post-indexed sum wraps
        run_indirect("R6", 4'd7, 32'h00000040, 32'h00000020, 1, 32'h00000040,
                     32'hFFFFFFF0, 32'h00000010);

        // R9: undefined codes
        for (int k = 0; k < 2; k++) begin
            mode = (k == 0) ? 4'd8 : 4'd15;
            base_val = 32'h11111111; index_val = 32'h2222; disp = 16'h0033;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check("R9", "done", {31'd0, done}, 32'd1);
            check("R9", "err", {31'd0, err}, 32'd1);
            check("R9", "ea zero", ea_out, 32'd0);
            check("R9", "no read", {31'd0, mem_req}, 32'd0);
            @(negedge clk);
            check("R9", "err drops", {31'd0, err}, 32'd0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule